// File: doc/BRIEF.md
# Zone Access Privilege Tracker

This block keeps track of the rights a host has earned over a small set of protected memory zones. Password checks, key authentication and encryption activation are computed elsewhere. The tracker is told which set or key was tried and whether the attempt passed. From that it keeps three things: the one password that is currently active, the key that is currently authenticated, and the communication mode. Each zone has a configuration byte. The tracker combines that byte with the held privileges and drives one read-grant and one write-grant line per zone.

Every password set and every key has its own failure counter. After a fixed number of failures the set or key is locked out for good, and later attempts on it fail whatever result is reported. If a message integrity check fails while the host is authenticated, everything is withdrawn. A host-driven card reset also withdraws all privileges, but it keeps the failure counters. The active-low `rst_n` is the power-on reset and clears all state. One password set can be given supervisor rights, which grants write access to every password set.

Top module: `zone_priv_tracker`

## Requirements
- R1: After `rst_n`, the mode is Standard (`comm_mode` 0) and no password or key is held. Zones whose configuration requires nothing are granted read and write; every other zone is denied, and `pwset_wr_ok` is all zeros.
- R2: Zone configuration bits: [2:0] password set, [4:3] key index, [5] password required, [6] authentication required, [7] encryption required. A successful read password grants read only, on zones that require a password and select that set. A successful write password grants read and write on those zones.
- R3: At most one password is held at a time. A successful presentation replaces the held one, and a failed presentation clears it.
- R4: A successful authentication enters Authentication mode (`comm_mode` 1) with that key, even when the mode was Encryption. A zone that requires authentication is granted only while the held key equals the zone's key index.
- R5: A failed authentication drops the held key and returns the mode to Standard. The held password is kept.
- R6: An encryption activation enters Encryption mode (`comm_mode` 2) only when it passes, a key is held, and its key equals the held key. Otherwise it has no effect. A zone that requires encryption is granted only in Encryption mode with the held key equal to the zone's key index.
- R7: A failed MAC check in Authentication or Encryption mode clears the held key and the held password and returns the mode to Standard. In Standard mode a MAC result has no effect, and a passing MAC never has any effect.
- R8: In a cycle in which privileges are revoked (card reset, or a failed MAC in a non-Standard mode), every password, authentication and encryption request is discarded. This includes its effect on the failure counters.
- R9: `card_rst` clears the held password, the held key and the mode, but keeps the failure counters.
- R10: After TRIAL_LIMIT (4) failures, a password set or key is locked, and every later attempt on it fails, even a passing one. Other sets and keys are not affected.
- R11: A passing attempt on a set or key that is not locked resets its failure count to zero.
- R12: While `supervisor_en` is high and the write password of set 7 is held, `pwset_wr_ok` is all ones. Otherwise only the bit of the held write password's set is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset, clears all state |
| card_rst | input | 1 | Host card reset, withdraws privileges |
| supervisor_en | input | 1 | Enables supervisor rights for password set 7 |
| zone_cfg | input | 32 | One 8-bit configuration field per zone, zone 0 in the low byte |
| pw_req | input | 1 | A password presentation result is valid |
| pw_sel | input | 3 | Password set presented |
| pw_is_write | input | 1 | 1 = write password, 0 = read password |
| pw_match | input | 1 | The presented value matched |
| auth_req | input | 1 | An authentication result is valid |
| auth_key_sel | input | 2 | Key used for the authentication |
| auth_pass | input | 1 | The authentication succeeded |
| enc_req | input | 1 | An encryption activation result is valid |
| enc_key_sel | input | 2 | Key used for the encryption activation |
| enc_pass | input | 1 | The activation succeeded |
| mac_chk | input | 1 | A MAC check result is valid |
| mac_match | input | 1 | The MAC matched |
| zone_rd_ok | output | 4 | Read granted, one bit per zone |
| zone_wr_ok | output | 4 | Write granted, one bit per zone |
| comm_mode | output | 2 | 0 Standard, 1 Authentication, 2 Encryption |
| pwset_wr_ok | output | 8 | Write access to each password set |

## Verification
Revocation and new requests can arrive in the same cycle. The bench presents a failed MAC check in Authentication mode together with a passing authentication on another key and a passing write password, and separately a card reset together with a passing write password. It judges the result from the mode, the zone grants and `pwset_wr_ok` one cycle later. A following encryption activation on the discarded key must then leave the mode at Standard.

// File: rtl/zpt_pkg.sv
// Shared types for the zone privilege tracker.
// Assumes: the mode is encoded on two bits and the value 3 is never used.
package zpt_pkg;
    typedef enum logic [1:0] {
        MODE_STD  = 2'd0,
        MODE_AUTH = 2'd1,
        MODE_ENC  = 2'd2
    } comm_mode_e;
endpackage

// File: rtl/zpt_attempt_bank.sv
// Bank of saturating failure counters, one per password set or key.
// It reports whether the current attempt is granted. An entry locks once
// its count reaches LIMIT, and after that it never grants again.
// Assumes: at most one attempt per cycle; try_valid is already gated by the caller.
module zpt_attempt_bank #(
    parameter int N     = 8,
    parameter int LIMIT = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             try_valid,
    input  logic [IDX_W-1:0] try_idx,
    input  logic             try_ok,
    output logic             grant
);
    logic [N-1:0] locked;

    for (genvar i = 0; i < N; i++) begin : g_entry
        logic [CNT_W-1:0] cnt_q;
        logic             hit;

        assign hit       = try_valid && (try_idx == IDX_W'(i));
        assign locked[i] = (cnt_q == CNT_W'(LIMIT));

        // Count failures; a pass before lock-out clears the count.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (hit && !locked[i]) begin
                cnt_q <= try_ok ? '0 : cnt_q + CNT_W'(1);
            end
        end

        assert_cnt_bound_R10 : assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNT_W'(LIMIT));
    end

    // Pass only for a good result on an entry that is not locked.
    always_comb begin
        grant = try_valid && try_ok && !locked[try_idx];
    end

    assert_lock_sticky_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(locked) & ~locked) == '0);
endmodule

// File: rtl/zpt_session.sv
// Session state: the one held password, the held key and the communication mode.
// Card reset or a failed MAC in a non-Standard mode revokes all of it, and
// the requests of that cycle are discarded, counters included.
// Assumes: the crypto and compare results arrive already computed, one per cycle per kind.
module zpt_session
    import zpt_pkg::*;
#(
    parameter int NUM_PW_SETS = 8,
    parameter int NUM_KEYS    = 4,
    parameter int TRIAL_LIMIT = 4,
    localparam int PW_W  = $clog2(NUM_PW_SETS),
    localparam int KEY_W = $clog2(NUM_KEYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_rst,
    input  logic             pw_req,
    input  logic [PW_W-1:0]  pw_sel,
    input  logic             pw_is_write,
    input  logic             pw_match,
    input  logic             auth_req,
    input  logic [KEY_W-1:0] auth_key_sel,
    input  logic             auth_pass,
    input  logic             enc_req,
    input  logic [KEY_W-1:0] enc_key_sel,
    input  logic             enc_pass,
    input  logic             mac_chk,
    input  logic             mac_match,
    output logic             pw_active_q,
    output logic [PW_W-1:0]  pw_set_q,
    output logic             pw_write_q,
    output logic             auth_active_q,
    output logic [KEY_W-1:0] auth_key_q,
    output comm_mode_e       mode_q
);
    logic revoke;
    logic pw_grant;
    logic auth_grant;
    logic enc_fits;

    // Revocation condition for this cycle.
    always_comb begin
        revoke = card_rst || (mac_chk && !mac_match && (mode_q != MODE_STD));
    end

    zpt_attempt_bank #(.N(NUM_PW_SETS), .LIMIT(TRIAL_LIMIT)) u_pw_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .try_valid (pw_req && !revoke),
        .try_idx   (pw_sel),
        .try_ok    (pw_match),
        .grant     (pw_grant)
    );

    zpt_attempt_bank #(.N(NUM_KEYS), .LIMIT(TRIAL_LIMIT)) u_key_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .try_valid (auth_req && !revoke),
        .try_idx   (auth_key_sel),
        .try_ok    (auth_pass),
        .grant     (auth_grant)
    );

    // Encryption may only start on the key that is held.
    always_comb begin
        enc_fits = enc_req && enc_pass && auth_active_q && (enc_key_sel == auth_key_q);
    end

    // Held password: replaced on a pass, cleared on a failure or a revocation.
    always_ff @(posedge clk) begin
        if (!rst_n || revoke) begin
            pw_active_q <= 1'b0;
            pw_set_q    <= '0;
            pw_write_q  <= 1'b0;
        end else if (pw_req) begin
            pw_active_q <= pw_grant;
            pw_set_q    <= pw_grant ? pw_sel : '0;
            pw_write_q  <= pw_grant && pw_is_write;
        end
    end

    // Held key and mode: authentication first, then encryption activation.
    always_ff @(posedge clk) begin
        if (!rst_n || revoke) begin
            auth_active_q <= 1'b0;
            auth_key_q    <= '0;
            mode_q        <= MODE_STD;
        end else if (auth_req) begin
            auth_active_q <= auth_grant;
            auth_key_q    <= auth_grant ? auth_key_sel : '0;
            mode_q        <= auth_grant ? MODE_AUTH : MODE_STD;
        end else if (enc_fits) begin
            mode_q <= MODE_ENC;
        end
    end

    assert_enc_needs_auth_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ENC) |-> auth_active_q);

    assert_mac_revoke_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (mac_chk && !mac_match && (mode_q != MODE_STD)) |=>
            ((mode_q == MODE_STD) && !pw_active_q && !auth_active_q));

    assert_card_rst_clear_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |=> ((mode_q == MODE_STD) && !pw_active_q && !auth_active_q));

    assert_std_without_key_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        !auth_active_q |-> (mode_q == MODE_STD));
endmodule

// File: rtl/zpt_zone_gate.sv
// Access decision for one zone. It combines the zone's configuration field
// with the held privileges and drives a read grant and a write grant.
// Assumes: field layout {enc_req, auth_req, pw_req, key[KEY_W], set[PW_W]}, LSB first.
module zpt_zone_gate
    import zpt_pkg::*;
#(
    parameter int PW_W  = 3,
    parameter int KEY_W = 2,
    localparam int CFG_W = PW_W + KEY_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic             pw_active,
    input  logic [PW_W-1:0]  pw_set,
    input  logic             pw_write,
    input  logic             auth_active,
    input  logic [KEY_W-1:0] auth_key,
    input  comm_mode_e       mode,
    output logic             rd_ok,
    output logic             wr_ok
);
    logic [PW_W-1:0]  c_set;
    logic [KEY_W-1:0] c_key;
    logic             c_need_pw, c_need_auth, c_need_enc;
    logic             pw_rd, pw_wr, key_ok, enc_ok;

    // Split the configuration field.
    always_comb begin
        c_set       = cfg[PW_W-1:0];
        c_key       = cfg[PW_W+KEY_W-1:PW_W];
        c_need_pw   = cfg[PW_W+KEY_W];
        c_need_auth = cfg[PW_W+KEY_W+1];
        c_need_enc  = cfg[PW_W+KEY_W+2];
    end

    // Each condition is met either because it is not required or because it is satisfied.
    always_comb begin
        pw_rd  = !c_need_pw || (pw_active && (pw_set == c_set));
        pw_wr  = !c_need_pw || (pw_active && pw_write && (pw_set == c_set));
        key_ok = !c_need_auth || (auth_active && (auth_key == c_key));
        enc_ok = !c_need_enc || ((mode == MODE_ENC) && (auth_key == c_key));
        rd_ok  = pw_rd && key_ok && enc_ok;
        wr_ok  = pw_wr && key_ok && enc_ok;
    end

    assert_wr_implies_rd_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> rd_ok);
endmodule

// File: rtl/zone_priv_tracker.sv
// Top level: session state, one access gate per zone, and the
// write rights over the password sets, including supervisor rights.
// Assumes: all inputs are synchronous to clk; the grants are combinational
// from registered state and the static configuration inputs.
module zone_priv_tracker
    import zpt_pkg::*;
#(
    parameter int NUM_ZONES   = 4,
    parameter int NUM_PW_SETS = 8,
    parameter int NUM_KEYS    = 4,
    parameter int TRIAL_LIMIT = 4,
    parameter int SUPER_SET   = 7,
    localparam int PW_W  = $clog2(NUM_PW_SETS),
    localparam int KEY_W = $clog2(NUM_KEYS),
    localparam int CFG_W = PW_W + KEY_W + 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       card_rst,
    input  logic                       supervisor_en,
    input  logic [NUM_ZONES*CFG_W-1:0] zone_cfg,
    input  logic                       pw_req,
    input  logic [PW_W-1:0]            pw_sel,
    input  logic                       pw_is_write,
    input  logic                       pw_match,
    input  logic                       auth_req,
    input  logic [KEY_W-1:0]           auth_key_sel,
    input  logic                       auth_pass,
    input  logic                       enc_req,
    input  logic [KEY_W-1:0]           enc_key_sel,
    input  logic                       enc_pass,
    input  logic                       mac_chk,
    input  logic                       mac_match,
    output logic [NUM_ZONES-1:0]       zone_rd_ok,
    output logic [NUM_ZONES-1:0]       zone_wr_ok,
    output logic [1:0]                 comm_mode,
    output logic [NUM_PW_SETS-1:0]     pwset_wr_ok
);
    logic             pw_active, pw_write, auth_active, super_on;
    logic [PW_W-1:0]  pw_set;
    logic [KEY_W-1:0] auth_key;
    comm_mode_e       mode;

    zpt_session #(
        .NUM_PW_SETS (NUM_PW_SETS),
        .NUM_KEYS    (NUM_KEYS),
        .TRIAL_LIMIT (TRIAL_LIMIT)
    ) u_session (
        .clk           (clk),
        .rst_n         (rst_n),
        .card_rst      (card_rst),
        .pw_req        (pw_req),
        .pw_sel        (pw_sel),
        .pw_is_write   (pw_is_write),
        .pw_match      (pw_match),
        .auth_req      (auth_req),
        .auth_key_sel  (auth_key_sel),
        .auth_pass     (auth_pass),
        .enc_req       (enc_req),
        .enc_key_sel   (enc_key_sel),
        .enc_pass      (enc_pass),
        .mac_chk       (mac_chk),
        .mac_match     (mac_match),
        .pw_active_q   (pw_active),
        .pw_set_q      (pw_set),
        .pw_write_q    (pw_write),
        .auth_active_q (auth_active),
        .auth_key_q    (auth_key),
        .mode_q        (mode)
    );

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        zpt_zone_gate #(.PW_W(PW_W), .KEY_W(KEY_W)) u_gate (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg         (zone_cfg[z*CFG_W +: CFG_W]),
            .pw_active   (pw_active),
            .pw_set      (pw_set),
            .pw_write    (pw_write),
            .auth_active (auth_active),
            .auth_key    (auth_key),
            .mode        (mode),
            .rd_ok       (zone_rd_ok[z]),
            .wr_ok       (zone_wr_ok[z])
        );
    end

    // Supervisor rights: write password of the designated set, feature enabled.
    always_comb begin
        super_on = supervisor_en && pw_active && pw_write && (pw_set == PW_W'(SUPER_SET));
    end

    for (genvar s = 0; s < NUM_PW_SETS; s++) begin : g_pwset
        // Write rights over one password set.
        always_comb begin
            pwset_wr_ok[s] = super_on || (pw_active && pw_write && (pw_set == PW_W'(s)));
        end
    end

    always_comb begin
        comm_mode = mode;
    end

    assert_pwset_onehot_R12 : assert property (@(posedge clk) disable iff (!rst_n)
        !supervisor_en |-> $onehot0(pwset_wr_ok));
endmodule

// File: tb/zone_priv_tracker_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes one expected item per operation,
// and the monitor pops it and compares it with the outputs 2 ns after the next rising edge.
module zone_priv_tracker_tb_top;
    typedef struct packed {
        logic [3:0] rd;
        logic [3:0] wr;
        logic [1:0] mode;
        logic [7:0] pws;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_rst = 1'b0;
    logic        supervisor_en = 1'b1;
    logic [31:0] zone_cfg = {8'h00, 8'h90, 8'h6D, 8'h22};
    logic        pw_req = 1'b0, pw_is_write = 1'b0, pw_match = 1'b0;
    logic [2:0]  pw_sel = '0;
    logic        auth_req = 1'b0, auth_pass = 1'b0;
    logic [1:0]  auth_key_sel = '0;
    logic        enc_req = 1'b0, enc_pass = 1'b0;
    logic [1:0]  enc_key_sel = '0;
    logic        mac_chk = 1'b0, mac_match = 1'b0;
    logic [3:0]  zone_rd_ok, zone_wr_ok;
    logic [1:0]  comm_mode;
    logic [7:0]  pwset_wr_ok;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    zone_priv_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .supervisor_en(supervisor_en),
        .zone_cfg(zone_cfg), .pw_req(pw_req), .pw_sel(pw_sel), .pw_is_write(pw_is_write),
        .pw_match(pw_match), .auth_req(auth_req), .auth_key_sel(auth_key_sel),
        .auth_pass(auth_pass), .enc_req(enc_req), .enc_key_sel(enc_key_sel),
        .enc_pass(enc_pass), .mac_chk(mac_chk), .mac_match(mac_match),
        .zone_rd_ok(zone_rd_ok), .zone_wr_ok(zone_wr_ok), .comm_mode(comm_mode),
        .pwset_wr_ok(pwset_wr_ok)
    );

    // Monitor: compare one expected item per clock.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() != 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if ({zone_rd_ok, zone_wr_ok, comm_mode, pwset_wr_ok} !== e) begin
                n_fail++;
                $display("FAIL %s: actual rd=%b wr=%b mode=%0d pws=%b expected rd=%b wr=%b mode=%0d pws=%b",
                         t, zone_rd_ok, zone_wr_ok, comm_mode, pwset_wr_ok,
                         e.rd, e.wr, e.mode, e.pws);
            end
        end
    end

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic pw(input logic [2:0] s, input logic w, input logic ok);
        pw_req = 1'b1; pw_sel = s; pw_is_write = w; pw_match = ok;
    endtask

    task automatic au(input logic [1:0] k, input logic ok);
        auth_req = 1'b1; auth_key_sel = k; auth_pass = ok;
    endtask

    task automatic en(input logic [1:0] k, input logic ok);
        enc_req = 1'b1; enc_key_sel = k; enc_pass = ok;
    endtask

    task automatic mac(input logic ok);
        mac_chk = 1'b1; mac_match = ok;
    endtask

    // Driver: push the expectation, let one edge pass, then drop all requests.
    task automatic chk(input string tag, input logic [3:0] rd, input logic [3:0] wr,
                       input logic [1:0] m, input logic [7:0] p);
        exp_q.push_back({rd, wr, m, p});
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        pw_req = 1'b0; auth_req = 1'b0; enc_req = 1'b0; mac_chk = 1'b0; card_rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        nxt(); rst_n = 1'b1;
        chk("R1 reset state", 4'b1000, 4'b1000, 2'd0, 8'h00);
        nxt(); pw(3'd2, 1'b0, 1'b1); chk("R2 read password", 4'b1001, 4'b1000, 2'd0, 8'h00);
        nxt(); pw(3'd2, 1'b1, 1'b1); chk("R2 write password", 4'b1001, 4'b1001, 2'd0, 8'h04);
        nxt(); pw(3'd5, 1'b1, 1'b1); chk("R3 replaced password", 4'b1000, 4'b1000, 2'd0, 8'h20);
        nxt(); au(2'd1, 1'b1); chk("R4 auth key1", 4'b1010, 4'b1010, 2'd1, 8'h20);
        nxt(); en(2'd2, 1'b1); chk("R6 enc key mismatch", 4'b1010, 4'b1010, 2'd1, 8'h20);
        nxt(); en(2'd1, 1'b1); chk("R6 enc key1", 4'b1010, 4'b1010, 2'd2, 8'h20);
        nxt(); au(2'd2, 1'b1); chk("R4 re-auth key2", 4'b1000, 4'b1000, 2'd1, 8'h20);
        nxt(); en(2'd2, 1'b1); chk("R6 enc zone grant", 4'b1100, 4'b1100, 2'd2, 8'h20);
        nxt(); mac(1'b1); chk("R7 mac match", 4'b1100, 4'b1100, 2'd2, 8'h20);
        nxt(); mac(1'b0); chk("R7 mac mismatch revoke", 4'b1000, 4'b1000, 2'd0, 8'h00);
        nxt(); en(2'd2, 1'b1); chk("R6 enc without key", 4'b1000, 4'b1000, 2'd0, 8'h00);
        nxt(); pw(3'd2, 1'b1, 1'b1); chk("R2 write password again", 4'b1001, 4'b1001, 2'd0, 8'h04);
        nxt(); mac(1'b0); chk("R7 mac ignored in standard", 4'b1001, 4'b1001, 2'd0, 8'h04);
        nxt(); au(2'd1, 1'b1); chk("R4 auth keeps password", 4'b1001, 4'b1001, 2'd1, 8'h04);
        nxt(); au(2'd1, 1'b0); chk("R5 failed re-auth", 4'b1001, 4'b1001, 2'd0, 8'h04);
        nxt(); au(2'd1, 1'b1); chk("R4 auth again", 4'b1001, 4'b1001, 2'd1, 8'h04);
        nxt(); mac(1'b0); au(2'd2, 1'b1); pw(3'd5, 1'b1, 1'b1);
        chk("R8 revoke beats requests", 4'b1000, 4'b1000, 2'd0, 8'h00);
        nxt(); en(2'd2, 1'b1); chk("R8 discarded auth not held", 4'b1000, 4'b1000, 2'd0, 8'h00);
        nxt(); pw(3'd7, 1'b1, 1'b1); chk("R12 supervisor", 4'b1000, 4'b1000, 2'd0, 8'hFF);
        nxt(); supervisor_en = 1'b0; chk("R12 supervisor off", 4'b1000, 4'b1000, 2'd0, 8'h80);
        nxt(); supervisor_en = 1'b1; au(2'd0, 1'b1); chk("R4 auth key0", 4'b1000, 4'b1000, 2'd1, 8'hFF);
        nxt(); card_rst = 1'b1; pw(3'd2, 1'b1, 1'b1);
        chk("R9 card reset clears", 4'b1000, 4'b1000, 2'd0, 8'h00);
        nxt(); pw(3'd3, 1'b1, 1'b1); chk("R3 set3 write", 4'b1000, 4'b1000, 2'd0, 8'h08);
        nxt(); pw(3'd3, 1'b1, 1'b0); chk("R3 failed clears", 4'b1000, 4'b1000, 2'd0, 8'h00);
        for (int k = 0; k < 4; k++) begin
            nxt(); pw(3'd2, 1'b1, 1'b0); chk("R10 set2 failure", 4'b1000, 4'b1000, 2'd0, 8'h00);
        end
        nxt(); pw(3'd2, 1'b1, 1'b1); chk("R10 locked write", 4'b1000, 4'b1000, 2'd0, 8'h00);
        nxt(); pw(3'd2, 1'b0, 1'b1); chk("R10 locked read", 4'b1000, 4'b1000, 2'd0, 8'h00);
        nxt(); pw(3'd3, 1'b1, 1'b1); chk("R10 other set free", 4'b1000, 4'b1000, 2'd0, 8'h08);
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < 3; k++) begin
                nxt(); pw(3'd4, 1'b1, 1'b0); chk("R11 set4 failure", 4'b1000, 4'b1000, 2'd0, 8'h00);
            end
            nxt(); pw(3'd4, 1'b1, 1'b1); chk("R11 count cleared", 4'b1000, 4'b1000, 2'd0, 8'h10);
        end
        for (int k = 0; k < 4; k++) begin
            nxt(); au(2'd3, 1'b0); chk("R10 key3 failure", 4'b1000, 4'b1000, 2'd0, 8'h10);
        end
        nxt(); au(2'd3, 1'b1); chk("R10 key3 locked", 4'b1000, 4'b1000, 2'd0, 8'h10);
        nxt(); au(2'd0, 1'b1); chk("R10 key0 free", 4'b1000, 4'b1000, 2'd1, 8'h10);
        nxt();
        while (exp_q.size() != 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule